// File: doc/BRIEF.md
# Floating-Point Register Stack Tracker

This block keeps the bookkeeping state of an eight-entry floating-point register stack. It holds the top-of-stack pointer, one empty flag per physical entry, a 16-bit status word with condition codes and exception flags, and a 16-bit control word. The register contents and the arithmetic are handled elsewhere. An instruction sequencer pulses one or more command inputs per cycle. Every command takes effect at the next rising clock edge.

The status output combines the stored word with the current pointer, which is placed in bits 13:11. The tag output has one bit per physical entry, and the bit is high when that entry holds a value. Compare results load a fixed condition-code pattern. Raising exception flags whose mask bits are clear in the control word also sets the error-summary and busy bits. If more than one pointer-moving command is requested in the same cycle, the block flags the request as illegal and ignores all of those moves.

Top module: `fp_stack_tracker`

## Requirements
- R1: After reset, `ctrl_o` is 0x037F, `status_o` is 0x0000, the pointer is 0 and `tags_o` is 0x00 (all entries empty).
- R2: A push moves the pointer down by one modulo 8, then marks the entry at the new pointer valid (`tags_o` bit set).
- R3: A pop marks the entry at the current pointer empty, then moves the pointer up by one modulo 8.
- R4: `status_o` bits 13:11 always show the 3-bit pointer. Every other bit comes from the stored status word.
- R5: The decrement-pointer and increment-pointer commands move the pointer by one modulo 8, leave all tags unchanged, and clear status bits 14, 10, 9 and 8 (mask 0x4700).
- R6: Freeing index i marks physical entry (pointer + i) mod 8 empty and leaves the pointer unchanged.
- R7: A compare changes only status bits 14, 10 and 8. `cmp_res_i` encodes the result: 0 = less gives 0x0100, 1 = equal gives 0x4000, 2 = greater gives 0x0000, 3 = unordered gives 0x4500. A compare takes effect after the 0x4700 clear of a same-cycle pointer move.
- R8: A raise ORs `raise_flags_i` into status bits 5:0. After that OR, if any flag in bits 5:0 has its mask bit (`ctrl_o` bits 5:0) clear, status bits 7 and 15 are also set. If every flag is masked, bits 7 and 15 are left alone.
- R9: A control write loads `cw_i` into `ctrl_o`. A raise in the same cycle uses the old mask. The write does not change the status word on its own.
- R10: `illegal_o` is high, combinationally, whenever more than one of push, pop, decrement and increment is requested. In that cycle none of those moves changes the pointer, the tags or the status word.
- R11: `init_i` reinitialises the block synchronously to the R1 state and overrides every other command in the same cycle.
- R12: When a push and a free target the same entry in one cycle, the push wins and the entry ends valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Reinitialise command |
| push_i | input | 1 | Push command |
| pop_i | input | 1 | Pop command |
| dec_i | input | 1 | Decrement pointer command |
| inc_i | input | 1 | Increment pointer command |
| free_i | input | 1 | Free entry command |
| free_idx_i | input | 3 | Entry index relative to the pointer |
| cmp_i | input | 1 | Load compare result |
| cmp_res_i | input | 2 | Compare result: 0 less, 1 equal, 2 greater, 3 unordered |
| raise_i | input | 1 | Raise exception flags |
| raise_flags_i | input | 6 | Flags to raise into status bits 5:0 |
| cw_we_i | input | 1 | Control word write enable |
| cw_i | input | 16 | Control word value |
| status_o | output | 16 | Status word with the pointer in bits 13:11 |
| tags_o | output | 8 | Valid bit per physical entry |
| ctrl_o | output | 16 | Current control word |
| illegal_o | output | 1 | More than one move requested this cycle |

## Verification
The assertions check on every cycle the pointer and tag effect of a lone push or pop, that an illegal move leaves the pointer alone, the unordered and greater compare patterns, the summary and busy bits after an unmasked raise, and the result of initialisation. Other behaviour can only be seen in the bench's scenarios. These are modulo-8 wraparound of the pointer and of the free index, whether other status bits survive a compare, a control write that does not act on the status word until the next raise, and the push-over-free priority on a shared entry.

// File: rtl/fp_stack_tracker.sv
module fp_stack_tracker #(
  parameter int DEPTH = 8,
  parameter logic [15:0] CW_INIT = 16'h037F
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     init_i,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic                     dec_i,
  input  logic                     inc_i,
  input  logic                     free_i,
  input  logic [$clog2(DEPTH)-1:0] free_idx_i,
  input  logic                     cmp_i,
  input  logic [1:0]               cmp_res_i,
  input  logic                     raise_i,
  input  logic [5:0]               raise_flags_i,
  input  logic                     cw_we_i,
  input  logic [15:0]              cw_i,
  output logic [15:0]              status_o,
  output logic [DEPTH-1:0]         tags_o,
  output logic [15:0]              ctrl_o,
  output logic                     illegal_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [15:0] PTR_MASK = 16'(((1 << PTR_W) - 1) << 11);
  localparam logic [15:0] CC_MASK  = 16'h4700;
  localparam logic [15:0] CMP_MASK = 16'h4500;

  logic [PTR_W-1:0] top_q, top_d;
  logic [DEPTH-1:0] empty_q, empty_d;
  logic [15:0]      sw_q, sw_d, cw_q, cw_d;
  logic [PTR_W-1:0] below, above, free_slot;
  logic [15:0]      cc_pat;

  assign below     = top_q - 1'b1;
  assign above     = top_q + 1'b1;
  assign free_slot = top_q + free_idx_i;
  assign illegal_o = $countones({push_i, pop_i, dec_i, inc_i}) > 1;

  always_comb begin
    case (cmp_res_i)
      2'd0:    cc_pat = 16'h0100;
      2'd1:    cc_pat = 16'h4000;
      2'd2:    cc_pat = 16'h0000;
      default: cc_pat = 16'h4500;
    endcase
  end

  always_comb begin
    top_d   = top_q;
    empty_d = empty_q;
    sw_d    = sw_q;
    cw_d    = cw_we_i ? cw_i : cw_q;
    if (free_i) empty_d[free_slot] = 1'b1;
    if (!illegal_o) begin
      if (push_i) begin
        top_d = below;
        empty_d[below] = 1'b0;
      end
      if (pop_i) begin
        empty_d[top_q] = 1'b1;
        top_d = above;
      end
      if (dec_i) begin
        top_d = below;
        sw_d  = sw_d & ~CC_MASK;
      end
      if (inc_i) begin
        top_d = above;
        sw_d  = sw_d & ~CC_MASK;
      end
    end
    if (cmp_i) sw_d = (sw_d & ~CMP_MASK) | cc_pat;
    if (raise_i) begin
      sw_d[5:0] = sw_d[5:0] | raise_flags_i;
      if ((sw_d[5:0] & ~cw_q[5:0]) != 6'd0) sw_d = sw_d | 16'h8080;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      top_q   <= '0;
      empty_q <= '1;
      sw_q    <= '0;
      cw_q    <= CW_INIT;
    end else begin
      top_q   <= top_d;
      empty_q <= empty_d;
      sw_q    <= sw_d;
      cw_q    <= cw_d;
    end
  end

  assign status_o = (sw_q & ~PTR_MASK) | (16'(top_q) << 11);
  assign tags_o   = ~empty_q;
  assign ctrl_o   = cw_q;

  a_r2_push_moves_down: assert property (@(posedge clk) disable iff (rst)
    push_i && !illegal_o && !init_i |=> !empty_q[top_q] && top_q == PTR_W'($past(top_q) - 1'b1));

  a_r3_pop_moves_up: assert property (@(posedge clk) disable iff (rst)
    pop_i && !illegal_o && !init_i |=> empty_q[$past(top_q)] && top_q == PTR_W'($past(top_q) + 1'b1));

  a_r10_illegal_holds_ptr: assert property (@(posedge clk) disable iff (rst)
    illegal_o && !init_i |=> $stable(top_q));

  a_r7_unordered: assert property (@(posedge clk) disable iff (rst)
    cmp_i && cmp_res_i == 2'd3 && !init_i |=> (status_o & CMP_MASK) == CMP_MASK);

  a_r7_greater: assert property (@(posedge clk) disable iff (rst)
    cmp_i && cmp_res_i == 2'd2 && !init_i |=> (status_o & CMP_MASK) == 16'h0000);

  a_r8_unmasked_summary: assert property (@(posedge clk) disable iff (rst)
    raise_i && !init_i && ((raise_flags_i & ~cw_q[5:0]) != 6'd0) |=> status_o[7] && status_o[15]);

  a_r11_init_state: assert property (@(posedge clk) disable iff (rst)
    init_i |=> ctrl_o == CW_INIT && status_o == 16'h0000 && tags_o == '0);
endmodule

// File: tb/fp_stack_tracker_tb.sv
module fp_stack_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_i = 0, push_i = 0, pop_i = 0, dec_i = 0, inc_i = 0, free_i = 0;
  logic [2:0] free_idx_i = 0;
  logic cmp_i = 0;
  logic [1:0] cmp_res_i = 0;
  logic raise_i = 0;
  logic [5:0] raise_flags_i = 0;
  logic cw_we_i = 0;
  logic [15:0] cw_i = 0;
  logic [15:0] status_o, ctrl_o;
  logic [7:0] tags_o;
  logic illegal_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_stack_tracker u_dut (
    .clk(clk), .rst(rst), .init_i(init_i), .push_i(push_i), .pop_i(pop_i),
    .dec_i(dec_i), .inc_i(inc_i), .free_i(free_i), .free_idx_i(free_idx_i),
    .cmp_i(cmp_i), .cmp_res_i(cmp_res_i), .raise_i(raise_i),
    .raise_flags_i(raise_flags_i), .cw_we_i(cw_we_i), .cw_i(cw_i),
    .status_o(status_o), .tags_o(tags_o), .ctrl_o(ctrl_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    init_i = 0; push_i = 0; pop_i = 0; dec_i = 0; inc_i = 0; free_i = 0;
    free_idx_i = 0; cmp_i = 0; cmp_res_i = 0; raise_i = 0; raise_flags_i = 0;
    cw_we_i = 0; cw_i = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_init();
    init_i = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 16'h0000);
    chk("R1 tags", {8'h00, tags_o}, 16'h0000);
    chk("R1 ctrl", ctrl_o, 16'h037F);
    chk("R10 idle not illegal", {15'b0, illegal_o}, 16'h0000);
  endtask

  task automatic t_push_pop();
    do_init();
    push_i = 1; tick();
    chk("R2 tags after push", {8'h00, tags_o}, 16'h0080);
    chk("R4 pointer field 7", status_o, 16'h3800);
    push_i = 1; tick();
    chk("R2 tags after 2nd push", {8'h00, tags_o}, 16'h00C0);
    chk("R4 pointer field 6", status_o, 16'h3000);
    pop_i = 1; tick();
    chk("R3 tags after pop", {8'h00, tags_o}, 16'h0080);
    chk("R3 pointer 7", status_o, 16'h3800);
    pop_i = 1; tick();
    chk("R3 tags empty", {8'h00, tags_o}, 16'h0000);
    chk("R3 pointer wraps to 0", status_o, 16'h0000);
    for (int k = 0; k < 8; k++) begin push_i = 1; tick(); end
    chk("R2 full stack tags", {8'h00, tags_o}, 16'h00FF);
    chk("R2 pointer wraps to 0", status_o, 16'h0000);
  endtask

  task automatic t_incdec();
    do_init();
    cmp_i = 1; cmp_res_i = 2'd3; tick();
    chk("R7 unordered", status_o, 16'h4500);
    dec_i = 1; tick();
    chk("R5 dec clears cc, ptr 7", status_o, 16'h3800);
    chk("R5 dec tags untouched", {8'h00, tags_o}, 16'h0000);
    push_i = 1; tick();
    inc_i = 1; tick();
    chk("R5 inc ptr 7", status_o, 16'h3800);
    chk("R5 inc tags untouched", {8'h00, tags_o}, 16'h0040);
    cmp_i = 1; cmp_res_i = 2'd1; inc_i = 1; tick();
    chk("R7 compare after same-cycle clear", status_o, 16'h4000);
  endtask

  task automatic t_free();
    do_init();
    for (int k = 0; k < 8; k++) begin push_i = 1; tick(); end
    dec_i = 1; tick();
    free_i = 1; free_idx_i = 3'd2; tick();
    chk("R6 free wraps to entry 1", {8'h00, tags_o}, 16'h00FD);
    chk("R6 pointer unchanged", status_o, 16'h3800);
  endtask

  task automatic t_cmp();
    do_init();
    raise_i = 1; raise_flags_i = 6'h21; tick();
    chk("R8 masked raise", status_o, 16'h0021);
    cmp_i = 1; cmp_res_i = 2'd0; tick();
    chk("R7 less", status_o, 16'h0121);
    cmp_i = 1; cmp_res_i = 2'd1; tick();
    chk("R7 equal", status_o, 16'h4021);
    cmp_i = 1; cmp_res_i = 2'd2; tick();
    chk("R7 greater", status_o, 16'h0021);
    cmp_i = 1; cmp_res_i = 2'd3; tick();
    chk("R7 unordered keeps flags", status_o, 16'h4521);
  endtask

  task automatic t_exc();
    do_init();
    raise_i = 1; raise_flags_i = 6'h04; tick();
    chk("R8 masked no summary", status_o, 16'h0004);
    cw_we_i = 1; cw_i = 16'h037B; tick();
    chk("R9 ctrl written", ctrl_o, 16'h037B);
    chk("R9 write alone leaves status", status_o, 16'h0004);
    raise_i = 1; raise_flags_i = 6'h01; tick();
    chk("R8 unmasked pending sets summary", status_o, 16'h8085);
    do_init();
    cw_we_i = 1; cw_i = 16'h0000; raise_i = 1; raise_flags_i = 6'h01; tick();
    chk("R9 same-cycle raise uses old mask", status_o, 16'h0001);
    raise_i = 1; raise_flags_i = 6'h00; tick();
    chk("R8 summary with new mask", status_o, 16'h8081);
  endtask

  task automatic t_illegal();
    do_init();
    push_i = 1; pop_i = 1; #1;
    chk("R10 push+pop flagged", {15'b0, illegal_o}, 16'h0001);
    tick();
    chk("R10 push+pop ignored tags", {8'h00, tags_o}, 16'h0000);
    chk("R10 push+pop ignored ptr", status_o, 16'h0000);
    cmp_i = 1; cmp_res_i = 2'd3; tick();
    push_i = 1; inc_i = 1; #1;
    chk("R10 push+inc flagged", {15'b0, illegal_o}, 16'h0001);
    tick();
    chk("R10 push+inc keeps status", status_o, 16'h4500);
    chk("R10 push+inc keeps tags", {8'h00, tags_o}, 16'h0000);
  endtask

  task automatic t_priority();
    do_init();
    push_i = 1; tick();
    push_i = 1; free_i = 1; free_idx_i = 3'd7; tick();
    chk("R12 push beats free", {8'h00, tags_o}, 16'h00C0);
  endtask

  task automatic t_init_cmd();
    push_i = 1; cw_we_i = 1; cw_i = 16'h1234; raise_i = 1; raise_flags_i = 6'h3F; tick();
    init_i = 1; push_i = 1; cw_we_i = 1; cw_i = 16'h5555; tick();
    chk("R11 init status", status_o, 16'h0000);
    chk("R11 init tags", {8'h00, tags_o}, 16'h0000);
    chk("R11 init ctrl", ctrl_o, 16'h037F);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_push_pop();
    t_incdec();
    t_free();
    t_cmp();
    t_exc();
    t_illegal();
    t_priority();
    t_init_cmd();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule